// File: doc/BRIEF.md
# NAND Chunk Hamming Parity Generator

This block builds a 24-bit single-error-correcting Hamming code over one 512-byte chunk of NAND page data while the bytes stream past it. Each data bit has a 12-bit bit address. The low three bits are the bit position inside the byte, and the upper nine bits are the byte offset inside the chunk. For every address bit the block keeps two parities: one over the data bits whose address bit is 1, and one over those whose address bit is 0. The parities are not inverted, so an erased chunk (all 0xFF) gives a code of zero.

A controller pulses the clear input at the start of a chunk and raises the enable. It then presents data strobes that carry one byte, or one 16-bit word, per cycle. Once the 512th byte has been absorbed the done flag rises, and the code can be read either as a 32-bit result word or as three packed spare-area bytes. Dropping the enable pauses accumulation without losing the position in the chunk.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, result and spare_bytes are 0 and done is 0.
- R2: For k in 0..11, with bit address A = {byte offset[8:0], bit position[2:0]}, result[16+k] is the XOR of all absorbed data bits with A[k]=1, and result[k] is the XOR of those with A[k]=0.
- R3: With bus16=0, each cycle with strb=1 absorbs din[7:0] as the next byte, so the byte offset rises by one per strobe starting at 0.
- R4: With bus16=1, each strobe absorbs din[7:0] at the next offset and then din[15:8] at the offset after it, so 256 words fill the chunk.
- R5: A chunk of 512 bytes of 0xFF gives result 0 and spare_bytes 0.
- R6: done rises on the cycle after the 512th byte is absorbed. Later strobes change neither result nor done until the next clear.
- R7: A clear pulse sets result to 0, done to 0 and the byte offset to 0. A strobe in the same cycle as the clear is discarded.
- R8: While eng_en=0, strobes are ignored. When eng_en returns to 1, accumulation continues at the offset where it stopped.
- R9: result[15:12] and result[31:28] are always 0.
- R10: spare_bytes[7:0] = result[7:0], spare_bytes[15:8] = result[23:16], and spare_bytes[23:16] = {result[27:24], result[11:8]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Engine enable; strobes count only while high |
| bus16 | input | 1 | Bus width select: 0 = 8-bit words, 1 = 16-bit words |
| clr | input | 1 | Clear pulse: zeroes the code, the offset and done |
| strb | input | 1 | Data strobe, one word per cycle |
| din | input | 16 | Data word; the low byte is used first |
| done | output | 1 | Chunk complete |
| result | output | 32 | Parity pairs: high half in 27:16, low half in 11:0 |
| spare_bytes | output | 24 | Code packed into three spare-area bytes |

## Verification
The hardest states to reach are the chunk boundary and the edges of a pause. At the boundary the 512th byte sets done, and every strobe after it has to be discarded. At a pause the offset must survive a stretch of ignored strobes. The bench streams full chunks in both bus widths, and the 16-bit chunk must give the same code as the 8-bit one. It then sends junk strobes with the enable low in the middle of a chunk, and extra strobes after done, and compares the result with a bit-level model that counts only the bytes that should have been absorbed. Clear and strobe are also driven in the same cycle to show that clear wins.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITIDX_W = 3;
  localparam int unsigned HALF_OFS = 16;

  typedef enum logic {
    BUS_X8  = 1'b0,
    BUS_X16 = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/ecc_byte_term.sv
module ecc_byte_term #(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned NPAR  = ADDR_W + ecc_pkg::BITIDX_W
) (
  input  logic                      use_i,
  input  logic [ecc_pkg::BYTE_W-1:0] data_i,
  input  logic [ADDR_W-1:0]         offs_i,
  output logic [NPAR-1:0]           hi_o,
  output logic [NPAR-1:0]           lo_o
);
  localparam int unsigned BI = ecc_pkg::BITIDX_W;

  logic byte_par;
  assign byte_par = use_i & (^data_i);

  // column parities: split by bit position inside the byte
  always_comb begin
    for (int k = 0; k < BI; k++) begin
      hi_o[k] = 1'b0;
      lo_o[k] = 1'b0;
      for (int j = 0; j < ecc_pkg::BYTE_W; j++) begin
        if (((j >> k) & 1) == 1) hi_o[k] = hi_o[k] ^ (use_i & data_i[j]);
        else                     lo_o[k] = lo_o[k] ^ (use_i & data_i[j]);
      end
    end
  end

  // row parities: the whole byte goes to one side per offset bit
  for (genvar g = 0; g < ADDR_W; g++) begin : g_row
    assign hi_o[BI+g] = byte_par &  offs_i[g];
    assign lo_o[BI+g] = byte_par & ~offs_i[g];
  end
endmodule

// File: rtl/ecc_chunk_ctr.sv
module ecc_chunk_ctr #(
  parameter int unsigned CHUNK_BYTES = 512,
  localparam int unsigned ADDR_W = $clog2(CHUNK_BYTES),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              two_i,
  output logic [ADDR_W-1:0] offs_o,
  output logic              last_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;

  assign offs_o = cnt_q[ADDR_W-1:0];
  assign last_o = (cnt_q == CNT_W'(CHUNK_BYTES - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (take_i) cnt_d = cnt_q + (two_i ? CNT_W'(2) : CNT_W'(1));
    done_d = (cnt_d == CNT_W'(CHUNK_BYTES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (clr_i || take_i) begin
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  // R6: done only rises from absorbed data
  a_r6_done_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(take_i));
  // R6: offset never passes the chunk end
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CHUNK_BYTES));
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int unsigned CHUNK_BYTES = 512,
  localparam int unsigned ADDR_W = $clog2(CHUNK_BYTES),
  localparam int unsigned NPAR   = ADDR_W + ecc_pkg::BITIDX_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eng_en,
  input  logic        bus16,
  input  logic        clr,
  input  logic        strb,
  input  logic [15:0] din,
  output logic        done,
  output logic [31:0] result,
  output logic [23:0] spare_bytes
);
  import ecc_pkg::*;

  localparam int unsigned PAD = HALF_OFS - NPAR;

  bus_mode_e        mode;
  logic             take, two, last;
  logic [ADDR_W-1:0] offs;
  logic [NPAR-1:0]  hi_q, lo_q, hi_d, lo_d;
  logic [NPAR-1:0]  hi0, lo0, hi1, lo1;

  assign mode = bus_mode_e'(bus16);
  assign take = eng_en & strb & ~done & ~clr;
  assign two  = (mode == BUS_X16) & ~last;

  ecc_chunk_ctr #(.CHUNK_BYTES(CHUNK_BYTES)) i_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .take_i(take), .two_i(two),
    .offs_o(offs), .last_o(last), .done_o(done)
  );

  ecc_byte_term #(.ADDR_W(ADDR_W)) i_term_lo (
    .use_i(take), .data_i(din[7:0]), .offs_i(offs), .hi_o(hi0), .lo_o(lo0)
  );

  ecc_byte_term #(.ADDR_W(ADDR_W)) i_term_hi (
    .use_i(take & two), .data_i(din[15:8]), .offs_i(offs + ADDR_W'(1)),
    .hi_o(hi1), .lo_o(lo1)
  );

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (clr) begin
      hi_d = '0;
      lo_d = '0;
    end else if (take) begin
      hi_d = hi_q ^ hi0 ^ hi1;
      lo_d = lo_q ^ lo0 ^ lo1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (clr || take) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign result      = {{PAD{1'b0}}, hi_q, {PAD{1'b0}}, lo_q};
  assign spare_bytes = {result[27:24], result[11:8], result[23:16], result[7:0]};

  // R7: clear empties the code and the done flag
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (result == 32'd0) && !done);
  // R8: idle engine holds its code
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_en && !clr) |=> $stable(result));
  // R6: finished chunk is frozen
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done && $stable(result));
endmodule

// File: tb/test_nand_hamming_ecc.sv
module test_nand_hamming_ecc;
  logic        clk = 1'b0;
  logic        rst_n, eng_en, bus16, clr, strb;
  logic [15:0] din;
  logic        done;
  logic [31:0] result;
  logic [23:0] spare_bytes;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] pat [512];

  always #10 clk = ~clk;

  nand_hamming_ecc i_nand_hamming_ecc (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .bus16(bus16), .clr(clr),
    .strb(strb), .din(din), .done(done), .result(result), .spare_bytes(spare_bytes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int n);
    logic [11:0] hi = '0, lo = '0;
    for (int a = 0; a < n; a++)
      for (int b = 0; b < 8; b++)
        if (pat[a][b]) begin
          int ad = a * 8 + b;
          for (int k = 0; k < 12; k++)
            if (((ad >> k) & 1) == 1) hi[k] = ~hi[k];
            else                      lo[k] = ~lo[k];
        end
    return {4'h0, hi, 4'h0, lo};
  endfunction

  function automatic logic [23:0] pack(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk); strb = 1'b1; din = w;
  endtask

  task automatic idle();
    @(negedge clk); strb = 1'b0; din = '0;
  endtask

  task automatic send8(input int from, input int to);
    for (int i = from; i < to; i++) put({8'h00, pat[i]});
    idle();
  endtask

  task automatic t_reset();
    check("R1 result", result, 32'd0);
    check("R1 spare", {8'd0, spare_bytes}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_first_bit();
    do_clear();
    eng_en = 1'b1; bus16 = 1'b0;
    put(16'h0001); idle();
    check("R2 R3 addr0 bit0", result, 32'h0000_0FFF);
    check("R10 pack addr0", {8'd0, spare_bytes}, 32'h000F_00FF);
    check("R9 pad", {24'd0, result[31:28], result[15:12]}, 32'd0);
  endtask

  task automatic t_last_bit();
    do_clear();
    for (int i = 0; i < 511; i++) pat[i] = 8'h00;
    pat[511] = 8'h80;
    send8(0, 512);
    check("R2 addr4095", result, 32'h0FFF_0000);
    check("R10 pack addr4095", {8'd0, spare_bytes}, 32'h00F0_FF00);
    check("R6 done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_erased();
    do_clear();
    for (int i = 0; i < 512; i++) pat[i] = 8'hFF;
    send8(0, 511);
    check("R6 not done at 511", {31'd0, done}, 32'd0);
    send8(511, 512);
    check("R5 erased result", result, 32'd0);
    check("R5 erased spare", {8'd0, spare_bytes}, 32'd0);
    check("R6 erased done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_pattern8();
    for (int i = 0; i < 512; i++) pat[i] = 8'((i * 37 + 11) ^ (i >> 3));
    do_clear();
    send8(0, 512);
    check("R3 pattern x8", result, model(512));
    check("R10 pattern pack", {8'd0, spare_bytes}, {8'd0, pack(model(512))});
    check("R9 pattern pad", {24'd0, result[31:28], result[15:12]}, 32'd0);
    put(16'h00A5); put(16'h003C); idle();
    check("R6 ignored after done", result, model(512));
    check("R6 done held", {31'd0, done}, 32'd1);
  endtask

  task automatic t_pattern16();
    do_clear();
    bus16 = 1'b1;
    for (int w = 0; w < 128; w++) put({pat[2*w+1], pat[2*w]});
    idle();
    check("R4 half chunk x16", result, model(256));
    check("R4 not done half", {31'd0, done}, 32'd0);
    for (int w = 128; w < 256; w++) put({pat[2*w+1], pat[2*w]});
    idle();
    check("R4 full chunk x16", result, model(512));
    check("R4 done x16", {31'd0, done}, 32'd1);
    bus16 = 1'b0;
  endtask

  task automatic t_pause();
    do_clear();
    send8(0, 100);
    eng_en = 1'b0;
    for (int i = 0; i < 5; i++) put(16'h5A5A);
    idle();
    check("R8 paused", result, model(100));
    eng_en = 1'b1;
    send8(100, 512);
    check("R8 resumed", result, model(512));
    check("R8 done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_clear_prio();
    send8(0, 3);
    @(negedge clk); clr = 1'b1; strb = 1'b1; din = 16'h00FF;
    @(negedge clk); clr = 1'b0; strb = 1'b0;
    check("R7 clear result", result, 32'd0);
    check("R7 clear done", {31'd0, done}, 32'd0);
    send8(0, 1);
    check("R7 offset restart", result, model(1));
  endtask

  initial begin
    rst_n = 1'b0; eng_en = 1'b0; bus16 = 1'b0; clr = 1'b0; strb = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_bit();
    t_last_bit();
    t_erased();
    t_pattern8();
    t_pattern16();
    t_pause();
    t_clear_prio();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule